// File: doc/BRIEF.md
# Variable-Length T-State Ring Counter

This block produces the one-hot timing states T0 to T(L-1) that step a small sequencer through its instruction phases. The cycle length L is chosen at run time, from 1 up to 18 states. Each state register sits in its own stage, built like a JK flip-flop. A stage takes J from the true output of the stage below it and K from that stage's complement output, so the single active bit moves up one position on every falling clock edge. Each stage drives both a true output and a complemented output.

When the last selected state is active, the counter raises a wrap strobe, and on the next falling edge it returns to T0. If a shorter length is selected while the active bit already lies beyond it, the next edge sends the counter back to T0. The same recovery applies to any vector that is not exactly one-hot. The clear is synchronous and active high and is sampled on the falling edge, like every other register in the block.

Top module: `tstate_ring`

## Requirements
- R1: With `clr` high at a falling edge, the next state is T0 alone: `t_state` = 1 (bit i of `t_state` is Ti) and `t_state_n` = all ones except bit 0.
- R2: After a clear, exactly one bit of `t_state` is high in every cycle.
- R3: On a falling edge where Ti is active and Ti is not the last selected state, the counter moves to T(i+1).
- R4: On a falling edge where the last selected state T(L-1) is active, the counter moves to T0.
- R5: A `len_sel` value of 0, or any value above 18, acts as a length of 18, so T17 is the last state.
- R6: `t_state_n` is always the bitwise complement of `t_state`.
- R7: `wrap` is high in exactly those cycles in which T(L-1) is active, with L decoded from the current `len_sel`.
- R8: A change of `len_sel` is applied at the next falling edge. If the active state then lies at or beyond the new length, the counter goes to T0. Otherwise it keeps counting under the new length.
- R9: With `len_sel` = 1, the counter stays in T0 and `wrap` stays high.
- R10: A clear has priority over a wrap or a shift that falls on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its falling edge |
| clr | input | 1 | Synchronous active-high clear to T0 |
| len_sel | input | 5 | Cycle length, 1..18; 0 or above 18 means 18 |
| t_state | output | 18 | One-hot state vector, bit i = Ti |
| t_state_n | output | 18 | Bitwise complement of t_state |
| wrap | output | 1 | High while the last selected state is active |

## Verification
Two actions can fall on the same falling edge: a length change and a wrap decision. The bench drives them together by rewriting `len_sel` in the cycle just before an edge. In one case the active state already sits beyond the new limit. In another the active state is exactly the new last state. In a third the length grows while the counter is mid-cycle. Clear against wrap is provoked by raising `clr` while `wrap` is high. In every case a bench-side index model gives the expected result: the counter must go to T0 or to the next state, with exactly one bit set.

// File: rtl/tring_pkg.sv
package tring_pkg;
  localparam int unsigned MAX_T = 18;
  localparam int unsigned LEN_W = $clog2(MAX_T + 1);
endpackage

// File: rtl/tring_len_dec.sv
module tring_len_dec #(
  parameter int unsigned N  = tring_pkg::MAX_T,
  parameter int unsigned LW = tring_pkg::LEN_W
) (
  input  logic [LW-1:0] len_sel,
  output logic [N-1:0]  last_mask,
  output logic [N-1:0]  beyond_mask
);
  logic [LW-1:0] eff;

  // zero or out-of-range lengths fall back to the full ring
  always_comb begin
    if (len_sel == '0 || len_sel > LW'(N)) eff = LW'(N);
    else                                   eff = len_sel;
  end

  for (genvar i = 0; i < N; i++) begin : g_mask
    assign last_mask[i]   = (eff == LW'(i + 1));
    assign beyond_mask[i] = (eff <= LW'(i));
  end

  // R5: the decoded length is always a legal ring size
  always_comb begin
    a_r5_eff_range: assert (eff >= LW'(1) && eff <= LW'(N));
    a_r5_one_last:  assert ($countones(last_mask) == 1);
  end
endmodule

// File: rtl/tring_stage.sv
module tring_stage (
  input  logic clk,
  input  logic load,
  input  logic init_val,
  input  logic j,
  input  logic k,
  output logic q,
  output logic qn
);
  logic nq;

  always_comb begin
    unique case ({j, k})
      2'b00:   nq = q;
      2'b01:   nq = 1'b0;
      2'b10:   nq = 1'b1;
      default: nq = ~q;
    endcase
  end

  always_ff @(negedge clk) begin
    if (load) begin
      q  <= init_val;
      qn <= ~init_val;
    end else begin
      q  <= nq;
      qn <= ~nq;
    end
  end
endmodule

// File: rtl/tring_ctrl.sv
module tring_ctrl #(
  parameter int unsigned N = tring_pkg::MAX_T
) (
  input  logic         clr,
  input  logic [N-1:0] state,
  input  logic [N-1:0] last_mask,
  input  logic [N-1:0] beyond_mask,
  output logic         at_last,
  output logic         illegal,
  output logic         restart
);
  always_comb begin
    at_last = |(state & last_mask);
    illegal = ($countones(state) != 1) || (|(state & beyond_mask));
    restart = clr || illegal || at_last;
  end
endmodule

// File: rtl/tstate_ring.sv
module tstate_ring #(
  parameter int unsigned N  = tring_pkg::MAX_T,
  parameter int unsigned LW = tring_pkg::LEN_W
) (
  input  logic          clk,
  input  logic          clr,
  input  logic [LW-1:0] len_sel,
  output logic [N-1:0]  t_state,
  output logic [N-1:0]  t_state_n,
  output logic          wrap
);
  logic [N-1:0] last_mask, beyond_mask, q, qn;
  logic at_last, illegal, restart;

  tring_len_dec #(.N(N), .LW(LW)) u_dec (
    .len_sel(len_sel), .last_mask(last_mask), .beyond_mask(beyond_mask)
  );

  tring_ctrl #(.N(N)) u_ctrl (
    .clr(clr), .state(q), .last_mask(last_mask), .beyond_mask(beyond_mask),
    .at_last(at_last), .illegal(illegal), .restart(restart)
  );

  for (genvar i = 0; i < N; i++) begin : g_stage
    if (i == 0) begin : g_head
      tring_stage u_st (
        .clk(clk), .load(restart), .init_val(1'b1),
        .j(1'b0), .k(1'b1), .q(q[i]), .qn(qn[i])
      );
    end else begin : g_body
      tring_stage u_st (
        .clk(clk), .load(restart), .init_val(1'b0),
        .j(q[i-1]), .k(qn[i-1]), .q(q[i]), .qn(qn[i])
      );
    end
  end

  assign t_state   = q;
  assign t_state_n = qn;
  assign wrap      = at_last;

  // arming history for the checks below
  logic [1:0] arm_q;
  always_ff @(negedge clk) begin
    if (clr) arm_q <= 2'b01;
    else     arm_q <= {arm_q[0], arm_q[0] | arm_q[1]};
  end

  a_r2_onehot: assert property (@(negedge clk) disable iff (clr || !arm_q[1])
    $countones(t_state) == 1);
  a_r6_complement: assert property (@(negedge clk) disable iff (clr || !arm_q[1])
    t_state_n == ~t_state);
  a_r3_shift: assert property (@(negedge clk) disable iff (clr || !arm_q[1])
    (!$past(clr) && !$past(at_last) && !$past(illegal)) |-> (t_state == ($past(t_state) << 1)));
  a_r4_wrap: assert property (@(negedge clk) disable iff (clr || !arm_q[1])
    $past(at_last) |-> (t_state == N'(1)));
  a_r10_clear: assert property (@(negedge clk) disable iff (!arm_q[1])
    $past(clr) |-> (t_state == N'(1)));
endmodule

// File: tb/test_tstate_ring.sv
`timescale 1ns/1ps
module test_tstate_ring;
  localparam int N = 18;
  logic clk = 1'b0;
  logic clr = 1'b0;
  logic [4:0] len_sel = 5'd5;
  logic [N-1:0] t_state, t_state_n;
  logic wrap;
  int total = 0;
  int bad = 0;
  int idx = 0;

  always #4 clk = ~clk;

  tstate_ring i_tstate_ring (
    .clk(clk), .clr(clr), .len_sel(len_sel),
    .t_state(t_state), .t_state_n(t_state_n), .wrap(wrap)
  );

  function automatic int eff_len(input logic [4:0] l);
    return (l == 0 || l > 18) ? 18 : int'(l);
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // inputs change just after the rising edge; the falling edge samples them
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check_outputs(input string tag);
    logic [N-1:0] e;
    e = N'(1) << idx;
    chk({tag, " state"}, t_state, e);
    chk("R6 complement", t_state_n, ~e);
    chk("R7 wrap", N'(wrap), N'(idx == eff_len(len_sel) - 1));
  endtask

  // one falling edge, model advanced with the len_sel applied at that edge
  task automatic step(input string tag);
    if (idx >= eff_len(len_sel) - 1) idx = 0;
    else idx = idx + 1;
    tick();
    check_outputs(tag);
  endtask

  task automatic do_clear();
    clr = 1'b1;
    tick();
    clr = 1'b0;
    idx = 0;
  endtask

  task automatic t_reset();
    len_sel = 5'd5;
    clr = 1'b1;
    tick();
    tick();
    clr = 1'b0;
    idx = 0;
    check_outputs("R1 reset");
    chk("R1 reset n", t_state_n, {{(N-1){1'b1}}, 1'b0});
  endtask

  task automatic t_run(input logic [4:0] l, input int n, input string tag);
    len_sel = l;
    do_clear();
    check_outputs(tag);
    for (int c = 0; c < n; c++) step(tag);
  endtask

  task automatic t_shrink();
    len_sel = 5'd18;
    do_clear();
    for (int c = 0; c < 10; c++) step("R3 pre-shrink");
    len_sel = 5'd4;              // active T10 lies beyond new length
    step("R8 shrink beyond");
    chk("R8 back to T0", t_state, N'(1));
    for (int c = 0; c < 6; c++) step("R8 after shrink");
  endtask

  task automatic t_grow_and_hit();
    len_sel = 5'd4;
    do_clear();
    for (int c = 0; c < 3; c++) step("R4 len4");
    len_sel = 5'd9;              // at T3, now mid-cycle
    step("R8 grow");
    chk("R8 grow continues", t_state, N'(1) << 4);
    for (int c = 0; c < 2; c++) step("R8 grown");
    len_sel = 5'd7;              // T6 becomes the last state
    #1;
    chk("R7 new last", N'(wrap), N'(1));
    step("R8 wrap on new last");
    chk("R4 wrap at new last", t_state, N'(1));
  endtask

  task automatic t_clear_on_wrap();
    len_sel = 5'd3;
    do_clear();
    step("R3 len3");
    step("R3 len3");
    chk("R10 wrap before clear", N'(wrap), N'(1));
    clr = 1'b1;
    tick();
    clr = 1'b0;
    idx = 0;
    check_outputs("R10 clear+wrap");
    step("R10 after");
    clr = 1'b1;                  // clear while mid-cycle at T1
    tick();
    clr = 1'b0;
    idx = 0;
    check_outputs("R1 clear mid");
  endtask

  initial begin
    t_reset();
    t_run(5'd5, 12, "R3 R4 len5");
    t_run(5'd18, 40, "R4 len18");
    t_run(5'd0, 40, "R5 len0");
    t_run(5'd25, 40, "R5 len25");
    t_run(5'd31, 20, "R5 len31");
    t_run(5'd1, 6, "R9 len1");
    t_run(5'd2, 6, "R2 len2");
    t_shrink();
    t_grow_and_hit();
    t_clear_on_wrap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule